// File: doc/BRIEF.md
# Chip-Selected Two-Wire Configuration Register Slave

This block is a two-wire serial (SMBus/I2C-style) target that exposes a small bank of 8-bit configuration registers to a host. The clock and data lines arrive as already-sampled synchronous inputs on a fast system clock. The block finds START and STOP conditions, shifts bytes in most-significant bit first, and pulls the data line low to acknowledge. The output `sdaOe` is an open-drain enable: when it is 1, the pad drives the line low.

A host selects the device by raising `chipSel`. It then writes a register pointer followed by one or more data bytes, and the pointer advances after each data byte. To read, the host sets the pointer, issues a repeated START and an address byte with the read bit set, and clocks data out until it answers with a NACK. The device's own 7-bit address is held in register 0x00 and can be rewritten. Register 0x01 holds a soft-reset bit that clears every other register but leaves the address alone. Three GPIO configuration registers, a GPIO input register and a GPIO output register complete the bank.

Top module: `smbus_cfg_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) begins a new address phase from any state, including mid-transaction (repeated START). A rising SDA while SCL is high (STOP) returns the block to idle. Bytes clocked while idle get no acknowledge.
- R2: The address byte is taken MSB first. The slave acknowledges it by driving SDA low during the ninth clock only when bits [7:1] equal the stored 7-bit address. On a mismatch it leaves SDA released and ignores the bus until the next START.
- R3: A write is an address byte with bit 0 = 0, then a pointer byte, then data bytes. The slave acknowledges each byte, and each further data byte goes to the pointer plus one.
- R4: After a repeated START and an address byte with bit 0 = 1, the slave shifts out the register at the pointer, MSB first. A master ACK (0) advances the pointer and sends the next register. A master NACK (1) ends the transfer.
- R5: Register 0x00 holds the device address in bits [7:1] and reads 0 in bit 0. After hard reset the address is 0x2C, so the register reads 0x58. A written address applies from the next address phase, and the old address is no longer acknowledged.
- R6: Writing register 0x01 with bit 0 = 1 clears registers 0x02 to 0x06 to zero but keeps register 0x00. Register 0x01 reads 0x00.
- R7: Registers 0x02, 0x03 and 0x04 are 8-bit read/write configuration words for GPIO 0, 1 and 2. Their fields are: [7:4] function select; [3:2] pull (00 none, 01 pull-down, 10 pull-up, 11 reserved); [1] input buffer enable; [0] output enable. They appear on `gpioCfg` as bits [8n+7:8n] for GPIO n.
- R8: Register 0x05 reads `gpioIn` in bits [2:0] with zeros above, and writes to it are ignored. Register 0x06 bits [2:0] drive `gpioOut`, and its upper bits read 0.
- R9: Register addresses 0x07 to 0xFF read 0x00, and writes to them change nothing.
- R10: While `chipSel` is low the slave never drives SDA, acknowledges nothing and writes no register. Dropping `chipSel` aborts any transfer.
- R11: After hard reset, `sdaOe`, `gpioOut` and `gpioCfg` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low hard reset |
| chipSel | input | 1 | Active-high bus qualifier |
| sclIn | input | 1 | Sampled serial clock line |
| sdaIn | input | 1 | Sampled serial data line |
| sdaOe | output | 1 | 1 = pull SDA low |
| gpioIn | input | 3 | GPIO pin levels, read at register 0x05 |
| gpioCfg | output | 24 | GPIO configuration words, 8 bits per pin |
| gpioOut | output | 3 | GPIO output levels from register 0x06 |

## Verification
The assertions check on every cycle that SDA is released while the chip select is low, that no register write happens without the chip select, and that the slave starts driving only while SCL is low. They also check that a soft reset clears the GPIO registers and keeps the address, that an address write takes effect, and that reserved writes leave all state unchanged. Only the bench scenarios can show the byte-level protocol: which address bytes are acknowledged, that the pointer advances across bursts, the repeated-START read path with master ACK and NACK, and the read values of every register. The bench checks these against a register model under random writes and reads.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;

  // Strobe bundle from the bus controller to the register datapath
  typedef struct packed {
    logic       wrStb;
    logic [7:0] regPtr;
    logic [7:0] wrData;
  } ctrlStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK
  } busState_t;

endpackage

// File: rtl/smbus_cfg_ctrl.sv
module smbus_cfg_ctrl
  import smbus_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chipSel,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [6:0]  devAddr,
  input  logic [7:0]  rdData,
  output ctrlStrobe_t strobe,
  output logic        sdaOe
);

  logic      sclEff, sdaEff, sclQ, sdaQ;
  logic      sclRise, sclFall, startEv, stopEv;
  busState_t state;
  logic [7:0] shiftReg, txByte, regPtr;
  logic [3:0] bitCnt;
  logic      rwBit, masterAck, ackDrive;

  // A deselected bus looks idle-high
  assign sclEff  = chipSel ? sclIn : 1'b1;
  assign sdaEff  = chipSel ? sdaIn : 1'b1;
  assign sclRise = sclEff & ~sclQ;
  assign sclFall = ~sclEff & sclQ;
  assign startEv = sclEff & sclQ & sdaQ & ~sdaEff;
  assign stopEv  = sclEff & sclQ & ~sdaQ & sdaEff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      state     <= ST_IDLE;
      shiftReg  <= '0;
      txByte    <= '0;
      regPtr    <= '0;
      bitCnt    <= '0;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
      ackDrive  <= 1'b0;
    end else begin
      sclQ <= sclEff;
      sdaQ <= sdaEff;
      if (!chipSel) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
      end else if (startEv) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        ackDrive <= 1'b0;
      end else if (stopEv) begin
        state    <= ST_IDLE;
        ackDrive <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (sclRise) begin
              shiftReg <= {shiftReg[6:0], sdaEff};
              bitCnt   <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              bitCnt <= '0;
              if (state == ST_ADDR) begin
                if (shiftReg[7:1] == devAddr) begin
                  rwBit    <= shiftReg[0];
                  ackDrive <= 1'b1;
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_PTR) begin
                regPtr   <= shiftReg;
                ackDrive <= 1'b1;
                state    <= ST_PTR_ACK;
              end else begin
                ackDrive <= 1'b1;
                state    <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            ackDrive <= 1'b0;
            if (rwBit) begin
              txByte <= rdData;
              state  <= ST_RDATA;
            end else begin
              state <= ST_PTR;
            end
          end
          ST_PTR_ACK: if (sclFall) begin
            ackDrive <= 1'b0;
            state    <= ST_WDATA;
          end
          ST_WDATA_ACK: if (sclFall) begin
            ackDrive <= 1'b0;
            regPtr   <= regPtr + 8'd1;
            state    <= ST_WDATA;
          end
          ST_RDATA: if (sclFall) begin
            if (bitCnt == 4'd7) begin
              bitCnt <= '0;
              state  <= ST_RDATA_ACK;
            end else begin
              txByte <= {txByte[6:0], 1'b0};
              bitCnt <= bitCnt + 4'd1;
            end
          end
          ST_RDATA_ACK: begin
            if (sclRise) begin
              masterAck <= ~sdaEff;
              if (!sdaEff) regPtr <= regPtr + 8'd1;
            end else if (sclFall) begin
              if (masterAck) begin
                txByte <= rdData;
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe = ackDrive | ((state == ST_RDATA) & ~txByte[7]);

  always_comb begin
    strobe.wrStb  = chipSel & ~startEv & ~stopEv & (state == ST_WDATA)
                    & sclFall & (bitCnt == 4'd8);
    strobe.regPtr = regPtr;
    strobe.wrData = shiftReg;
  end

endmodule

// File: rtl/smbus_cfg_regs.sv
module smbus_cfg_regs
  import smbus_cfg_pkg::*;
#(
  parameter int         NGPIO    = 3,
  parameter logic [6:0] DEF_ADDR = 7'h2C
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [NGPIO-1:0]     gpioIn,
  output logic [6:0]           devAddr,
  output logic [7:0]           rdData,
  output logic [NGPIO*8-1:0]   gpioCfg,
  output logic [NGPIO-1:0]     gpioOut
);

  localparam logic [7:0] REG_ADDR = 8'd0;
  localparam logic [7:0] REG_SRST = 8'd1;
  localparam int         CFG_BASE = 2;
  localparam logic [7:0] REG_IN   = 8'(CFG_BASE + NGPIO);
  localparam logic [7:0] REG_OUT  = 8'(CFG_BASE + NGPIO + 1);

  logic softRst;
  assign softRst = strobe.wrStb & (strobe.regPtr == REG_SRST) & strobe.wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      devAddr <= DEF_ADDR;
    else if (strobe.wrStb && strobe.regPtr == REG_ADDR)
      devAddr <= strobe.wrData[7:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gpioOut <= '0;
    else if (softRst)
      gpioOut <= '0;
    else if (strobe.wrStb && strobe.regPtr == REG_OUT)
      gpioOut <= strobe.wrData[NGPIO-1:0];
  end

  for (genvar g = 0; g < NGPIO; g++) begin : gCfg
    logic [7:0] cfgQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cfgQ <= '0;
      else if (softRst)
        cfgQ <= '0;
      else if (strobe.wrStb && strobe.regPtr == 8'(CFG_BASE + g))
        cfgQ <= strobe.wrData;
    end
    assign gpioCfg[g*8 +: 8] = cfgQ;
  end

  always_comb begin
    rdData = '0;
    if (strobe.regPtr == REG_ADDR) rdData = {devAddr, 1'b0};
    if (strobe.regPtr == REG_IN)   rdData[NGPIO-1:0] = gpioIn;
    if (strobe.regPtr == REG_OUT)  rdData[NGPIO-1:0] = gpioOut;
    for (int g = 0; g < NGPIO; g++)
      if (strobe.regPtr == 8'(CFG_BASE + g)) rdData = gpioCfg[g*8 +: 8];
  end

endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter int         NGPIO    = 3,
  parameter logic [6:0] DEF_ADDR = 7'h2C
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               chipSel,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaOe,
  input  logic [NGPIO-1:0]   gpioIn,
  output logic [NGPIO*8-1:0] gpioCfg,
  output logic [NGPIO-1:0]   gpioOut
);

  ctrlStrobe_t strobe;
  logic [6:0]  devAddr;
  logic [7:0]  rdData;

  smbus_cfg_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .chipSel (chipSel),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .devAddr (devAddr),
    .rdData  (rdData),
    .strobe  (strobe),
    .sdaOe   (sdaOe)
  );

  smbus_cfg_regs #(.NGPIO(NGPIO), .DEF_ADDR(DEF_ADDR)) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .gpioIn  (gpioIn),
    .devAddr (devAddr),
    .rdData  (rdData),
    .gpioCfg (gpioCfg),
    .gpioOut (gpioOut)
  );

endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk
  import smbus_cfg_pkg::*;
#(
  parameter int NGPIO = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               chipSel,
  input logic               sclIn,
  input logic               sdaOe,
  input ctrlStrobe_t        strobe,
  input logic [6:0]         devAddr,
  input logic [NGPIO*8-1:0] gpioCfg,
  input logic [NGPIO-1:0]   gpioOut
);

  localparam logic [7:0] RSV_BASE = 8'(NGPIO + 4);

  logic softWr;
  assign softWr = strobe.wrStb && strobe.regPtr == 8'd1 && strobe.wrData[0];

  AST_NO_DRIVE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !chipSel |=> !sdaOe); // R10

  AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStb |-> chipSel); // R10

  AST_DRIVE_STARTS_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn); // R2

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> (gpioOut == '0 && gpioCfg == '0)); // R6

  AST_SOFT_RESET_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> $stable(devAddr)); // R6

  AST_ADDR_WRITE_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && strobe.regPtr == 8'd0) |=> devAddr == $past(strobe.wrData[7:1])); // R5

  AST_RESERVED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrStb && strobe.regPtr >= RSV_BASE) |=>
      ($stable(gpioOut) && $stable(gpioCfg) && $stable(devAddr))); // R9

endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk #(.NGPIO(NGPIO)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .chipSel (chipSel),
  .sclIn   (sclIn),
  .sdaOe   (sdaOe),
  .strobe  (strobe),
  .devAddr (devAddr),
  .gpioCfg (gpioCfg),
  .gpioOut (gpioOut)
);

// File: tb/smbus_cfg_slave_test.sv
module smbus_cfg_slave_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipSel = 1'b1;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaOe;
  logic        sdaLine;
  logic [2:0]  gpioIn = 3'b000;
  logic [23:0] gpioCfg;
  logic [2:0]  gpioOut;

  int checks = 0;
  int errors = 0;

  // Bench register model
  logic [6:0] mAddr = 7'h2C;
  logic [7:0] mCfg [3];
  logic [2:0] mOut;

  assign sdaLine = sdaM & ~sdaOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbus_cfg_slave uut (
    .clk(clk), .rstN(rstN), .chipSel(chipSel), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .gpioIn(gpioIn), .gpioCfg(gpioCfg), .gpioOut(gpioOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitH(); sclM = 1'b1; waitH(); sdaM = 1'b0; waitH(); sclM = 1'b0; waitH();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitH(); sclM = 1'b1; waitH(); sdaM = 1'b1; waitH();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ackBit);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitH(); sclM = 1'b1; waitH(); sclM = 1'b0; waitH();
    end
    sdaM = 1'b1; waitH(); sclM = 1'b1; waitH();
    ackBit = sdaLine;
    sclM = 1'b0; waitH();
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitH(); sclM = 1'b1; waitH(); b[i] = sdaLine; sclM = 1'b0;
    end
    waitH(); sdaM = nack; waitH(); sclM = 1'b1; waitH(); sclM = 1'b0; waitH();
  endtask

  task automatic writeReg(input logic [7:0] p, input logic [7:0] d, output logic acks);
    logic a0, a1, a2;
    busStart();
    sendByte({mAddr, 1'b0}, a0);
    sendByte(p, a1);
    sendByte(d, a2);
    busStop();
    acks = a0 | a1 | a2;
  endtask

  task automatic readReg(input logic [7:0] p, output logic [7:0] v, output logic acks);
    logic a0, a1, a2;
    busStart();
    sendByte({mAddr, 1'b0}, a0);
    sendByte(p, a1);
    busStart();
    sendByte({mAddr, 1'b1}, a2);
    recvByte(1'b1, v);
    busStop();
    acks = a0 | a1 | a2;
  endtask

  function automatic void applyWrite(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'h00) mAddr = d[7:1];
    else if (p == 8'h01) begin
      if (d[0]) begin
        for (int i = 0; i < 3; i++) mCfg[i] = 8'h00;
        mOut = 3'b000;
      end
    end else if (p >= 8'h02 && p <= 8'h04) mCfg[p - 8'h02] = d;
    else if (p == 8'h06) mOut = d[2:0];
  endfunction

  function automatic logic [7:0] expRead(input logic [7:0] p);
    if (p == 8'h00) return {mAddr, 1'b0};
    if (p >= 8'h02 && p <= 8'h04) return mCfg[p - 8'h02];
    if (p == 8'h05) return {5'b0, gpioIn};
    if (p == 8'h06) return {5'b0, mOut};
    return 8'h00;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, a0, a1, a2, a3, a4;
    logic [7:0] v, v1, v2;
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) mCfg[i] = 8'h00;
    mOut = 3'b000;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R11 reset state
    chk("R11 sdaOe", {31'b0, sdaOe}, 0);
    chk("R11 gpioOut", {29'b0, gpioOut}, 0);
    chk("R11 gpioCfg", {8'b0, gpioCfg}, 0);

    // R5 default address register
    readReg(8'h00, v, ack);
    chk("R5 default ack", {31'b0, ack}, 0);
    chk("R5 default addr reg", {24'b0, v}, 32'h58);

    // R1 byte clocked without START is not acknowledged
    sendByte({mAddr, 1'b0}, ack);
    chk("R1 no START no ack", {31'b0, ack}, 1);
    busStop();

    // R2 wrong address not acknowledged, later traffic ignored
    busStart();
    sendByte({7'h11, 1'b0}, a0);
    sendByte(8'h06, a1);
    sendByte(8'h07, a2);
    busStop();
    chk("R2 mismatch addr nack", {31'b0, a0}, 1);
    chk("R2 mismatch ptr ignored", {31'b0, a1}, 1);
    chk("R2 mismatch no write", {29'b0, gpioOut}, 0);

    // R3 R7 burst write to cfg registers
    busStart();
    sendByte({mAddr, 1'b0}, a0);
    sendByte(8'h02, a1);
    sendByte(8'h21, a2);
    sendByte(8'h96, a3);
    sendByte(8'hEA, a4);
    busStop();
    applyWrite(8'h02, 8'h21); applyWrite(8'h03, 8'h96); applyWrite(8'h04, 8'hEA);
    chk("R3 burst acks", {27'b0, a0, a1, a2, a3, a4}, 0);
    chk("R7 gpioCfg port", {8'b0, gpioCfg}, 32'hEA9621);

    // R4 burst read with master ACK then NACK
    busStart();
    sendByte({mAddr, 1'b0}, a0);
    sendByte(8'h02, a1);
    busStart();
    sendByte({mAddr, 1'b1}, a2);
    recvByte(1'b0, v);
    recvByte(1'b0, v1);
    recvByte(1'b1, v2);
    busStop();
    chk("R4 read acks", {29'b0, a0, a1, a2}, 0);
    chk("R4 read byte0", {24'b0, v}, 32'h21);
    chk("R4 read byte1", {24'b0, v1}, 32'h96);
    chk("R4 read byte2", {24'b0, v2}, 32'hEA);
    chk("R4 released after NACK", {31'b0, sdaOe}, 0);

    // R8 output and input registers
    writeReg(8'h06, 8'hFD, ack); applyWrite(8'h06, 8'hFD);
    chk("R8 out ack", {31'b0, ack}, 0);
    chk("R8 gpioOut", {29'b0, gpioOut}, 32'h5);
    readReg(8'h06, v, ack);
    chk("R8 out readback", {24'b0, v}, 32'h05);
    gpioIn = 3'b110;
    writeReg(8'h05, 8'hFF, ack);
    readReg(8'h05, v, ack);
    chk("R8 in readback", {24'b0, v}, 32'h06);
    chk("R8 in write no effect", {8'b0, gpioCfg, 5'b0, gpioOut},
        {8'b0, 24'hEA9621, 5'b0, 3'b101});

    // R9 reserved registers
    writeReg(8'h07, 8'hAA, ack);
    chk("R9 reserved write ack", {31'b0, ack}, 0);
    readReg(8'h07, v, ack);
    chk("R9 reserved read 07", {24'b0, v}, 0);
    readReg(8'h80, v, ack);
    chk("R9 reserved read 80", {24'b0, v}, 0);
    chk("R9 ports unchanged", {5'b0, gpioOut, gpioCfg}, {5'b0, 3'b101, 24'hEA9621});

    // R5 address rewrite
    writeReg(8'h00, 8'h6F, ack);
    applyWrite(8'h00, 8'h6F);
    busStart();
    sendByte({7'h2C, 1'b0}, a0);
    busStop();
    chk("R5 old addr nack", {31'b0, a0}, 1);
    readReg(8'h00, v, ack);
    chk("R5 new addr ack", {31'b0, ack}, 0);
    chk("R5 addr reg bit0 zero", {24'b0, v}, 32'h6E);

    // R6 soft reset
    writeReg(8'h01, 8'h01, ack); applyWrite(8'h01, 8'h01);
    chk("R6 gpio cleared", {5'b0, gpioOut, gpioCfg}, 0);
    readReg(8'h00, v, ack);
    chk("R6 addr kept", {23'b0, ack, v}, 32'h6E);
    readReg(8'h01, v, ack);
    chk("R6 reset reg reads 0", {24'b0, v}, 0);

    // R10 chip select low
    chipSel = 1'b0;
    writeReg(8'h06, 8'h07, ack);
    chk("R10 deselected nack", {31'b0, ack}, 1);
    chk("R10 deselected no write", {29'b0, gpioOut}, 0);
    chk("R10 deselected no drive", {31'b0, sdaOe}, 0);
    chipSel = 1'b1;
    repeat (4) @(negedge clk);

    // R10 deselect mid-transfer aborts
    busStart();
    sendByte({mAddr, 1'b0}, a0);
    sendByte(8'h06, a1);
    chipSel = 1'b0;
    sendByte(8'h07, a2);
    busStop();
    chipSel = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 abort no write", {29'b0, gpioOut}, 0);

    // Random register traffic against model (R3 R4 R7 R8 R9 R6)
    for (int k = 0; k < 30; k++) begin
      logic [7:0] p, d, q;
      p = 8'(1 + ($urandom % 9));
      d = 8'($urandom);
      gpioIn = 3'($urandom);
      writeReg(p, d, ack);
      applyWrite(p, d);
      chk("R3 random write ack", {31'b0, ack}, 0);
      chk("R7 random cfg port", {8'b0, gpioCfg}, {8'b0, mCfg[2], mCfg[1], mCfg[0]});
      chk("R8 random out port", {29'b0, gpioOut}, {29'b0, mOut});
      q = 8'($urandom % 10);
      readReg(q, v, ack);
      chk("R4 random read", {23'b0, ack, v}, {24'b0, expRead(q)});
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule